// File: doc/BRIEF.md
# Self-Rewriting Key Byte Bank

This block holds a sixteen-byte cipher key and hands one of its bytes to a byte-serial cipher core on every clock. An active pointer picks the byte on offer. Each time the core finishes a sub-round and pulses the step strobe, the pointer moves forward by a fixed stride.

On every seventh step, the block also refreshes the two bytes just ahead of the active pointer. Each of them is XORed with the active byte and then passed through its own substitution box, which is the AES S-box. Both writes land in the same clock as the step. The active byte is never rewritten. No step is ever held back, so the core sees no dead cycles.

A parallel load brings in a fresh key and a start pointer. The load also restarts the step counter.

Top module: `rekey_keybank`

## Requirements
- R1: When `load_en` is high at a clock edge, the block does three things. Every byte i is loaded from `key_in[8i+7:8i]`. `p2_ptr` takes the value of `start_ptr`. The step count restarts from zero. After reset, all bytes, `p2_ptr` and the step count are zero.
- R2: `key_byte` always equals the stored byte addressed by `p2_ptr`, in the same cycle.
- R3: A step with `load_en` low moves `p2_ptr` to (p2_ptr + 3) mod 16 at the clock edge.
- R4: `rekey` is high during the 7th step after a load or reset, and then during every 7th step after that. It is low in all other cycles.
- R5: In a `rekey` cycle with active byte k[p], two bytes change at the edge. Byte (p+1) mod 16 becomes S(k[p+1] ^ k[p]). Byte (p+2) mod 16 becomes S(k[p+2] ^ k[p]). S is the AES S-box, so S(0x00)=0x63.
- R6: A rekey cycle leaves the active byte and the other thirteen bytes unchanged.
- R7: With `step` and `load_en` both low, the pointer, the step count and all bytes hold their values.
- R8: If `load_en` and `step` are high together, the load wins. No advance and no rekey takes place.
- R9: `p3_ptr` equals (p2_ptr + 1) mod 16, and `p4_ptr` equals (p2_ptr + 2) mod 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Parallel key load |
| key_in | input | 128 | Key bytes; byte i sits at bits 8i+7:8i |
| start_ptr | input | 4 | Pointer value taken on load |
| step | input | 1 | One pulse per sub-round |
| key_byte | output | 8 | Byte at the active pointer |
| p2_ptr | output | 4 | Active pointer |
| p3_ptr | output | 4 | First trailing rewrite position |
| p4_ptr | output | 4 | Second trailing rewrite position |
| rekey | output | 1 | High in a rewrite cycle |

## Verification
The assertions check several rules on every cycle. They check the stride advance and the pointer taken on load. They check that two rewrite cycles are never adjacent and that the pointer holds while idle. They also check that neither rewrite port ever targets the active byte, and that the active byte keeps its value across a rewrite.

Some behaviours only the bench's scenarios can show. These are the S-box values written back and the exact seven-step spacing of `rekey`. They also include load priority over a simultaneous step and the state of each byte across long runs. The bench's reference model reveals these as the pointer sweeps every byte.

// File: rtl/rk_pkg.sv
package rk_pkg;
  localparam int KB = 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
    end
    return acc;
  endfunction

  // a^254 is the multiplicative inverse in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] t;
    r = 8'h01;
    t = a;
    for (int i = 0; i < 8; i++) begin
      if (((254 >> i) & 1) == 1) r = gf_mul(r, t);
      t = gf_mul(t, t);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] v;
    logic [7:0] o;
    v = gf_inv(x);
    for (int i = 0; i < 8; i++)
      o[i] = v[i] ^ v[(i + 4) % 8] ^ v[(i + 5) % 8] ^ v[(i + 6) % 8] ^ v[(i + 7) % 8];
    return o ^ 8'h63;
  endfunction

  function automatic int ptr_add(input int p, input int d, input int n);
    return (p + d) % n;
  endfunction
endpackage

// File: rtl/rk_sbox.sv
module rk_sbox (
  input  logic [7:0] din,
  output logic [7:0] dout
);
  import rk_pkg::*;
  assign dout = sbox(din);
endmodule

// File: rtl/rk_ptr_gen.sv
module rk_ptr_gen #(
  parameter int NBYTES = 16,
  parameter int STRIDE = 3,
  parameter int PERIOD = 7,
  localparam int PW = $clog2(NBYTES),
  localparam int CW = $clog2(PERIOD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [PW-1:0] start_ptr,
  input  logic          step,
  output logic [PW-1:0] p2,
  output logic [PW-1:0] p3,
  output logic [PW-1:0] p4,
  output logic          rekey
);
  import rk_pkg::*;

  logic [CW-1:0] cnt;
  logic          adv;
  logic          wrap;

  assign adv   = step && !load_en;
  assign wrap  = (cnt == CW'(PERIOD - 1));
  assign rekey = adv && wrap;
  assign p3    = PW'(ptr_add(int'(p2), 1, NBYTES));
  assign p4    = PW'(ptr_add(int'(p2), 2, NBYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p2  <= '0;
      cnt <= '0;
    end else if (load_en) begin
      p2  <= start_ptr;
      cnt <= '0;
    end else if (step) begin
      p2  <= PW'(ptr_add(int'(p2), STRIDE, NBYTES));
      cnt <= wrap ? '0 : cnt + 1'b1;
    end
  end

  assert_p2_stride_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> int'(p2) == ptr_add(int'($past(p2)), STRIDE, NBYTES));
  assert_load_ptr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> p2 == $past(start_ptr));
  assert_rekey_spaced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rekey |=> !rekey);
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_en) |=> $stable(p2));
endmodule

// File: rtl/rk_byte_bank.sv
module rk_byte_bank #(
  parameter int NBYTES = 16,
  localparam int PW = $clog2(NBYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [NBYTES*8-1:0] key_in,
  input  logic               wr_en,
  input  logic [PW-1:0]      wa_idx,
  input  logic [7:0]         wa_data,
  input  logic [PW-1:0]      wb_idx,
  input  logic [7:0]         wb_data,
  input  logic [PW-1:0]      rd_idx,
  output logic [7:0]         rd_data,
  output logic [7:0]         ra_data,
  output logic [7:0]         rb_data
);
  logic [7:0] bank [NBYTES];

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        bank[i] <= 8'h00;
      else if (load_en)
        bank[i] <= key_in[8*i +: 8];
      else if (wr_en && wa_idx == PW'(i))
        bank[i] <= wa_data;
      else if (wr_en && wb_idx == PW'(i))
        bank[i] <= wb_data;
    end
  end

  assign rd_data = bank[rd_idx];
  assign ra_data = bank[wa_idx];
  assign rb_data = bank[wb_idx];

  assert_no_self_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wa_idx != rd_idx) && (wb_idx != rd_idx));
  assert_active_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !load_en) |=> bank[$past(rd_idx)] == $past(rd_data));
endmodule

// File: rtl/rekey_keybank.sv
module rekey_keybank #(
  parameter int NBYTES = 16,
  parameter int STRIDE = 3,
  parameter int PERIOD = 7,
  localparam int PW = $clog2(NBYTES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [NBYTES*8-1:0] key_in,
  input  logic [PW-1:0]       start_ptr,
  input  logic                step,
  output logic [7:0]          key_byte,
  output logic [PW-1:0]       p2_ptr,
  output logic [PW-1:0]       p3_ptr,
  output logic [PW-1:0]       p4_ptr,
  output logic                rekey
);
  logic [7:0] act_byte;
  logic [7:0] trail_q [2];
  logic [7:0] trail_d [2];

  rk_ptr_gen #(.NBYTES(NBYTES), .STRIDE(STRIDE), .PERIOD(PERIOD)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .start_ptr(start_ptr),
    .step(step), .p2(p2_ptr), .p3(p3_ptr), .p4(p4_ptr), .rekey(rekey)
  );

  rk_byte_bank #(.NBYTES(NBYTES)) u_bank (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .key_in(key_in),
    .wr_en(rekey), .wa_idx(p3_ptr), .wa_data(trail_d[0]),
    .wb_idx(p4_ptr), .wb_data(trail_d[1]), .rd_idx(p2_ptr),
    .rd_data(act_byte), .ra_data(trail_q[0]), .rb_data(trail_q[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_sb
    rk_sbox u_sb (.din(trail_q[g] ^ act_byte), .dout(trail_d[g]));
  end

  assign key_byte = act_byte;
endmodule

// File: tb/rekey_keybank_test.sv
module rekey_keybank_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         load_en = 0;
  logic [127:0] key_in = '0;
  logic [3:0]   start_ptr = '0;
  logic         step = 0;
  logic [7:0]   key_byte;
  logic [3:0]   p2_ptr, p3_ptr, p4_ptr;
  logic         rekey;

  int n_chk = 0, n_bad = 0;
  int mk[16];
  int mp = 0, mc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rekey_keybank uut (.clk(clk), .rst_n(rst_n), .load_en(load_en), .key_in(key_in),
    .start_ptr(start_ptr), .step(step), .key_byte(key_byte), .p2_ptr(p2_ptr),
    .p3_ptr(p3_ptr), .p4_ptr(p4_ptr), .rekey(rekey));

  function automatic int pmul(int a, int b);
    int r = 0;
    for (int i = 0; i < 8; i++) if ((b >> i) & 1) r = r ^ (a << i);
    for (int i = 14; i >= 8; i--) if ((r >> i) & 1) r = r ^ (32'h11b << (i - 8));
    return r;
  endfunction

  function automatic int rotl(int v, int s);
    return ((v << s) | (v >> (8 - s))) & 255;
  endfunction

  function automatic int ref_s(int x);
    int inv = 0;
    for (int y = 1; y < 256; y++) if (pmul(x, y) == 1) inv = y;
    return inv ^ rotl(inv, 1) ^ rotl(inv, 2) ^ rotl(inv, 3) ^ rotl(inv, 4) ^ 8'h63;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(bit ld, logic [127:0] k, int sp, bit st);
    bit rk;
    int a, b;
    load_en = ld; key_in = k; start_ptr = 4'(sp); step = st;
    #1;
    rk = st && !ld && (mc == 6);
    chk("R2 key_byte", int'(key_byte), mk[mp]);
    chk("R3 p2_ptr", int'(p2_ptr), mp);
    chk("R9 p3_ptr", int'(p3_ptr), (mp + 1) % 16);
    chk("R9 p4_ptr", int'(p4_ptr), (mp + 2) % 16);
    chk("R4 rekey", int'(rekey), int'(rk));
    @(posedge clk);
    if (ld) begin
      for (int i = 0; i < 16; i++) mk[i] = int'(k[8*i +: 8]);
      mp = sp; mc = 0;
    end else if (st) begin
      if (rk) begin
        a = mk[(mp + 1) % 16]; b = mk[(mp + 2) % 16];
        mk[(mp + 1) % 16] = ref_s(a ^ mk[mp]);
        mk[(mp + 2) % 16] = ref_s(b ^ mk[mp]);
        mc = 0;
      end else mc++;
      mp = (mp + 3) % 16;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [127:0] kk;
    for (int i = 0; i < 16; i++) mk[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R1)
    chk("R1 reset p2", int'(p2_ptr), 0);
    chk("R1 reset byte", int'(key_byte), 0);
    chk("R5 sbox ref 00", ref_s(0), 8'h63);
    chk("R5 sbox ref 01", ref_s(1), 8'h7c);
    // all-zero key, rekey writes 0x63 (R5, R6)
    for (int i = 0; i < 30; i++) cyc(0, '0, 0, 1);
    // incrementing key, start pointer 5 (R1)
    for (int i = 0; i < 16; i++) kk[8*i +: 8] = 8'(i * 17 + 3);
    cyc(1, kk, 5, 0);
    chk("R1 loaded byte at start", int'(key_byte), 5 * 17 + 3);
    for (int i = 0; i < 50; i++) cyc(0, kk, 0, 1);
    // idle gaps hold state (R7)
    for (int i = 0; i < 40; i++) cyc(0, kk, 0, (i % 3) == 0);
    // load together with step: load wins (R8)
    kk = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    for (int i = 0; i < 6; i++) cyc(0, kk, 0, 1);
    cyc(1, kk, 14, 1);
    chk("R8 load over step p2", int'(p2_ptr), 14);
    for (int i = 0; i < 200; i++) cyc(0, kk, 0, (i % 5) != 4);
    // reload mid-count, then long run
    cyc(1, {4{32'hdeadbeef}}, 15, 0);
    for (int i = 0; i < 400; i++) cyc(0, '0, 0, 1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule